// File: doc/BRIEF.md
# Multichannel Absolute Time Stamper

This core gives every hit on sixteen independent inputs an absolute arrival time. A free-running 48-bit coarse counter advances once per 6.25 ns clock cycle (160 MHz). At that rate it takes roughly twenty days to wrap. Each channel also samples a 32-tap thermometer vector from an external delay line. The core turns that vector into a 5-bit fine position inside the clock period. The coarse and fine parts are joined into one 53-bit timestamp.

The coarse value is latched on the same clock edge that takes the tap vector, so the two parts always belong together. After a hit is accepted, the channel stays blind for 64 cycles (400 ns). Each channel stores one pending word. A round-robin arbiter moves the pending words onto a single readout port that uses a valid/ready handshake. A hit that finds its channel's slot still occupied is dropped, and the channel's sticky overflow flag is raised.

Top module: `tstamp_top`

## Requirements
- R1: While `rst` is high at a clock edge, the coarse counter, the dead timers, the pending slots and the overflow flags are cleared. After reset, `outValid` is 0 and `overflowFlag` is all zeros.
- R2: `outStamp[52:5]` is the coarse count at the capturing edge. That count is the number of clock edges since reset was released, with the first edge after release counting as 0.
- R3: `outStamp[4:0]` is the length of the unbroken run of ones that starts at tap bit 0 of the channel's 32-bit tap slice (`tapIn[c*32 +: 32]`). The code saturates at 31. Any bits after the first zero have no effect.
- R4: A hit accepted at edge E starts that channel's dead time. Hits on that channel at edges E+1 through E+63 are ignored. A hit at edge E+64 is accepted.
- R5: Suppose a hit arrives outside the dead time while the channel's slot is still full. That hit is dropped, the stored word is left unchanged, and `overflowFlag[c]` goes to 1. The flag stays at 1 until reset.
- R6: A word leaves only at an edge where `outValid` and `outReady` are both 1. While `outValid` is 1 and `outReady` is 0, `outValid`, `outChan` and `outStamp` keep their values.
- R7: After channel c has been read out, the next word granted comes from the first pending channel found when searching c+1, c+2 and onward, wrapping modulo 16.
- R8: The channels are independent. A hit on one channel is accepted even while another channel is in its dead time.
- R9: `outChan` is the 4-bit index of the channel whose timestamp is on `outStamp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 160 MHz clock, also the coarse time base |
| rst | input | 1 | Synchronous active-high reset |
| hitIn | input | 16 | Per-channel hit strobe, sampled at each edge |
| tapIn | input | 512 | Sampled delay-line taps, 32 bits per channel, channel c at [c*32 +: 32] |
| outReady | input | 1 | Readout sink can accept a word |
| outValid | output | 1 | A timestamp word is offered |
| outChan | output | 4 | Channel number of the offered word |
| outStamp | output | 53 | Coarse count (bits 52:5) and fine code (bits 4:0) |
| overflowFlag | output | 16 | Sticky per-channel overflow flags |

## Verification
The embedded properties check several rules on every cycle. The coarse counter steps by exactly one. A channel never captures on two edges in a row. Overflow flags never fall. A read-out channel's slot empties. An offered word stays frozen while it is stalled. Some behaviour can only be shown by the directed scenarios, because it needs a numeric reference built outside the design. That covers the exact absolute coarse value, the fine code for bubbled and saturated tap patterns, the exact 64-edge dead-time boundary, the rule that a dropped hit leaves the stored word unchanged, and the round-robin service order.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  parameter int NUM_CH   = 16;
  parameter int COARSE_W = 48;
  parameter int TAPS     = 32;
  parameter int DEAD_CYC = 64;

  localparam int FINE_W  = $clog2(TAPS);
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int STAMP_W = COARSE_W + FINE_W;
  localparam int DEAD_W  = $clog2(DEAD_CYC + 1);

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] capture;
    logic [CH_W-1:0]   sel;
  } strobe_t;
endpackage

// File: rtl/tstamp_fine_enc.sv
module tstamp_fine_enc
  import tstamp_pkg::*;
(
  input  logic [TAPS-1:0]   taps,
  output logic [FINE_W-1:0] code
);
  logic [FINE_W:0] runLen;
  logic            broken;

  // length of the leading run of ones from tap 0; bubbles after a zero ignored
  always_comb begin
    runLen = '0;
    broken = 1'b0;
    for (int i = 0; i < TAPS; i++) begin
      if (!broken && taps[i]) runLen = runLen + 1'b1;
      else                    broken = 1'b1;
    end
    if (runLen > (FINE_W+1)'(TAPS-1)) code = FINE_W'(TAPS-1);
    else                              code = runLen[FINE_W-1:0];
  end
endmodule

// File: rtl/tstamp_ctrl.sv
module tstamp_ctrl
  import tstamp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hitIn,
  input  logic              outReady,
  output logic              outValid,
  output logic [CH_W-1:0]   outChan,
  output logic [NUM_CH-1:0] overflowFlag,
  output strobe_t           strobe
);
  logic [DEAD_W-1:0] deadCnt [NUM_CH];
  logic [NUM_CH-1:0] full, live, capture;
  logic [CH_W-1:0]   rrPtr, pick, probeIdx, heldIdx, sel;
  logic              held, found, fire;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      assign live[c]    = hitIn[c] && (deadCnt[c] == '0);
      assign capture[c] = live[c] && !full[c];

      always_ff @(posedge clk) begin
        if (rst)                   deadCnt[c] <= '0;
        else if (live[c])          deadCnt[c] <= DEAD_W'(DEAD_CYC - 1);
        else if (deadCnt[c] != '0) deadCnt[c] <= deadCnt[c] - 1'b1;
      end

      always_ff @(posedge clk) begin
        if (rst)                                full[c] <= 1'b0;
        else if (capture[c])                    full[c] <= 1'b1;
        else if (fire && sel == CH_W'(c))       full[c] <= 1'b0;
      end

      always_ff @(posedge clk) begin
        if (rst)                     overflowFlag[c] <= 1'b0;
        else if (live[c] && full[c]) overflowFlag[c] <= 1'b1;
      end

      assert_dead_R4: assert property (@(posedge clk) disable iff (rst)
        capture[c] |=> !capture[c]);
      assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        overflowFlag[c] |=> overflowFlag[c]);
      assert_drain_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && sel == CH_W'(c)) |=> !full[c]);
    end
  endgenerate

  // round-robin search starting at rrPtr
  always_comb begin
    pick     = rrPtr;
    probeIdx = rrPtr;
    found    = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      probeIdx = rrPtr + CH_W'(i);
      if (!found && full[probeIdx]) begin
        pick  = probeIdx;
        found = 1'b1;
      end
    end
  end

  assign sel      = held ? heldIdx : pick;
  assign outValid = |full;
  assign outChan  = sel;
  assign fire     = outValid && outReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= 1'b0;
      heldIdx <= '0;
      rrPtr   <= '0;
    end else begin
      held    <= outValid && !outReady;
      heldIdx <= sel;
      if (fire) rrPtr <= sel + 1'b1;
    end
  end

  assign strobe.capture = capture;
  assign strobe.sel     = sel;
endmodule

// File: rtl/tstamp_datapath.sv
module tstamp_datapath
  import tstamp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CH*TAPS-1:0] tapIn,
  input  strobe_t                strobe,
  output logic [STAMP_W-1:0]     outStamp
);
  logic [COARSE_W-1:0] coarseCnt;
  logic [FINE_W-1:0]   fineCode  [NUM_CH];
  logic [STAMP_W-1:0]  stampHold [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) coarseCnt <= '0;
    else     coarseCnt <= coarseCnt + 1'b1;
  end

  assert_coarse_step_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> coarseCnt == $past(coarseCnt) + 1'b1);

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      tstamp_fine_enc u_enc (
        .taps (tapIn[c*TAPS +: TAPS]),
        .code (fineCode[c])
      );
      // coarse and taps sampled on the same edge
      always_ff @(posedge clk) begin
        if (rst)                    stampHold[c] <= '0;
        else if (strobe.capture[c]) stampHold[c] <= {coarseCnt, fineCode[c]};
      end
    end
  endgenerate

  assign outStamp = stampHold[strobe.sel];
endmodule

// File: rtl/tstamp_top.sv
module tstamp_top
  import tstamp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CH-1:0]      hitIn,
  input  logic [NUM_CH*TAPS-1:0] tapIn,
  input  logic                   outReady,
  output logic                   outValid,
  output logic [CH_W-1:0]        outChan,
  output logic [STAMP_W-1:0]     outStamp,
  output logic [NUM_CH-1:0]      overflowFlag
);
  strobe_t strobe;

  tstamp_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .hitIn        (hitIn),
    .outReady     (outReady),
    .outValid     (outValid),
    .outChan      (outChan),
    .overflowFlag (overflowFlag),
    .strobe       (strobe)
  );

  tstamp_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .tapIn    (tapIn),
    .strobe   (strobe),
    .outStamp (outStamp)
  );

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> outValid && $stable(outChan) && $stable(outStamp));
endmodule

// File: tb/sim_tstamp_top.sv
module sim_tstamp_top;
  localparam int CLK_PERIOD = 6;
  localparam int NCH = 16;
  localparam int NT  = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NCH-1:0]  hitIn = '0;
  logic [NCH*NT-1:0] tapIn = '0;
  logic            outReady = 1'b0;
  logic            outValid;
  logic [3:0]      outChan;
  logic [52:0]     outStamp;
  logic [NCH-1:0]  overflowFlag;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [47:0] cyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench's own edge count since reset release
  always @(posedge clk) cyc <= rst ? 48'd0 : cyc + 48'd1;

  tstamp_top u0 (
    .clk(clk), .rst(rst), .hitIn(hitIn), .tapIn(tapIn), .outReady(outReady),
    .outValid(outValid), .outChan(outChan), .outStamp(outStamp),
    .overflowFlag(overflowFlag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one-cycle hit; returns coarse value the design will capture
  task automatic pulseHit(input int ch, input logic [31:0] taps, output logic [47:0] coarse);
    @(negedge clk);
    hitIn[ch] = 1'b1;
    tapIn[ch*NT +: NT] = taps;
    coarse = cyc;
    @(negedge clk);
    hitIn[ch] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R1 valid after reset", 64'(outValid), 64'd0);
    chk("R1 overflow after reset", 64'(overflowFlag), 64'd0);
  endtask

  task automatic test_single;
    logic [47:0] c;
    outReady = 1'b0;
    pulseHit(3, 32'h0000_007F, c);
    chk("R6 valid offered", 64'(outValid), 64'd1);
    chk("R9 channel number", 64'(outChan), 64'd3);
    chk("R2 R3 stamp", 64'(outStamp), 64'({c, 5'd7}));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 stalled word stable", 64'({outValid, outChan, outStamp}), 64'({1'b1, 4'd3, c, 5'd7}));
    end
    outReady = 1'b1;
    @(negedge clk);
    chk("R6 word gone after transfer", 64'(outValid), 64'd0);
  endtask

  task automatic test_bubble;
    logic [47:0] c;
    outReady = 1'b1;
    pulseHit(7, 32'h0000_031F, c);
    chk("R3 bubble after first zero ignored", 64'(outStamp), 64'({c, 5'd5}));
    pulseHit(8, 32'hFFFF_FFFF, c);
    chk("R3 all ones saturates", 64'(outStamp), 64'({c, 5'd31}));
    pulseHit(10, 32'hFFFF_FFFE, c);
    chk("R3 tap0 low gives zero", 64'(outStamp), 64'({c, 5'd0}));
    idle(2);
  endtask

  task automatic test_dead;
    logic [47:0] c0;
    outReady = 1'b1;
    @(negedge clk);
    hitIn[1] = 1'b1;
    tapIn[1*NT +: NT] = 32'h0000_0007;
    c0 = cyc;
    @(negedge clk);
    chk("R4 first hit accepted", 64'(outStamp), 64'({c0, 5'd3}));
    for (int k = 1; k < 64; k++) begin
      @(negedge clk);
      if (outValid !== 1'b0) chk("R4 hit during dead time ignored", 64'(outValid), 64'd0);
    end
    chk("R4 no word inside dead time", 64'(outValid), 64'd0);
    @(negedge clk);
    hitIn[1] = 1'b0;
    chk("R4 hit at edge +64 accepted", 64'({outValid, outStamp}), 64'({1'b1, c0 + 48'd64, 5'd3}));
    idle(70);
  endtask

  task automatic test_indep;
    logic [47:0] ca, cb;
    outReady = 1'b1;
    pulseHit(11, 32'h1, ca);
    chk("R9 first channel", 64'(outChan), 64'd11);
    @(negedge clk);
    hitIn[12] = 1'b1;
    tapIn[12*NT +: NT] = 32'h3;
    cb = cyc;
    @(negedge clk);
    hitIn[12] = 1'b0;
    chk("R8 other channel accepted during dead time", 64'({outValid, outChan, outStamp}),
        64'({1'b1, 4'd12, cb, 5'd2}));
    idle(70);
  endtask

  task automatic test_overflow;
    logic [47:0] ca, cb;
    outReady = 1'b0;
    pulseHit(5, 32'h0000_000F, ca);
    idle(70);
    chk("R5 no overflow yet", 64'(overflowFlag[5]), 64'd0);
    pulseHit(5, 32'h0000_00FF, cb);
    chk("R5 overflow raised", 64'(overflowFlag[5]), 64'd1);
    chk("R5 stored word unchanged", 64'(outStamp), 64'({ca, 5'd4}));
    outReady = 1'b1;
    @(negedge clk);
    chk("R5 dropped hit not queued", 64'(outValid), 64'd0);
    idle(3);
    chk("R5 overflow sticky", 64'(overflowFlag), 64'h0020);
    idle(70);
  endtask

  task automatic test_rr;
    outReady = 1'b0;
    @(negedge clk);
    hitIn[2] = 1'b1; hitIn[9] = 1'b1; hitIn[14] = 1'b1;
    @(negedge clk);
    hitIn = '0;
    outReady = 1'b1;
    chk("R7 first grant after ch5", 64'(outChan), 64'd9);
    @(negedge clk);
    chk("R7 second grant", 64'(outChan), 64'd14);
    @(negedge clk);
    chk("R7 wrap grant", 64'(outChan), 64'd2);
    @(negedge clk);
    chk("R7 queue empty", 64'(outValid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_single();
    test_bubble();
    test_dead();
    test_indep();
    test_overflow();
    test_rr();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule